// File: doc/BRIEF.md
# Bank-switched dual-port memory

This block is a two-port synchronous memory divided into four equal banks. Each bank has one ownership input. That input gives the bank to the left port or to the right port. Each port has its own enable, write strobe, byte-lane enables, address, write data, read data and access-error flag. Ownership is exclusive and comes from outside the block, so the block needs no arbiter. Both ports can work at full rate in the same cycle, each in a bank it owns, and neither port ever stalls the other.

A port that addresses a bank it does not own is refused. The refused access does not change the array. It returns zero on that port's read data, and the port's error flag pulses for one cycle. Software on each side then sets up the ownership inputs to pass a whole bank from one side to the other at a point it chooses. Because the ownership inputs are registered, a change takes effect only at the following clock edge.

Top module: `bank_dpram`

## Requirements
- R1: A port address is `BANK_AW+2` bits wide. Its two most significant bits pick the bank (0 to 3) and the remaining `BANK_AW` bits pick the word within that bank. The same word offset in different banks names separate storage.
- R2: `bank_sel[b]` = 1 gives bank b to the left port and 0 gives it to the right port. The value is taken at each rising clock edge. While reset is asserted, and until the first edge after reset, every bank belongs to the right port.
- R3: A read (enable high, write strobe low) to an owned bank returns the addressed word on that port's read data after the next rising edge, and the error flag stays low.
- R4: A write to an owned bank updates only the byte lanes whose enable bit is set. Bit i of the byte-lane enable covers data bits 8i+7..8i. A write leaves that port's read data unchanged.
- R5: Any access to a bank the port does not own leaves the array unchanged. It sets that port's read data to zero and raises its error flag for exactly the cycle after the access.
- R6: The two ports can each read or write a bank they own in the same cycle, and each gets the same result it would get alone.
- R7: Any split of ownership is allowed, from all four banks on one port to all four on the other.
- R8: An access issued in the same cycle that an ownership input changes is judged by the old ownership. The new owner applies from the following cycle.
- R9: During reset both read data outputs are zero and both error flags are low.
- R10: A cycle with a port's enable low leaves that port's read data unchanged and its error flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_sel | input | 4 | Per-bank owner: 1 = left, 0 = right |
| l_en | input | 1 | Left access enable |
| l_we | input | 1 | Left write strobe (0 = read) |
| l_be | input | DW/8 | Left byte-lane enables |
| l_addr | input | BANK_AW+2 | Left address {bank, word} |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left registered read data |
| l_err | output | 1 | Left access-error pulse |
| r_en | input | 1 | Right access enable |
| r_we | input | 1 | Right write strobe (0 = read) |
| r_be | input | DW/8 | Right byte-lane enables |
| r_addr | input | BANK_AW+2 | Right address {bank, word} |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right registered read data |
| r_err | output | 1 | Right access-error pulse |

## Verification
The hardest case to reach is the cycle in which an ownership input flips while an access to that same bank is already being presented. That access must still be refused, and the next access must go through. The stimulus changes `bank_sel` on the same falling edge that drives a read to the affected bank, checks for an error, and repeats the read one cycle later to confirm it is accepted. A second hard case is proving that a refused write left the array alone. For that, the rightful owner writes a known word, the other port's write to that word is refused, and the owner reads the word back.

// File: rtl/bank_dpram.sv
module bank_dpram #(
  parameter int BANK_AW = 8,
  parameter int DW      = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           bank_sel,
  input  logic                 l_en,
  input  logic                 l_we,
  input  logic [DW/8-1:0]      l_be,
  input  logic [BANK_AW+1:0]   l_addr,
  input  logic [DW-1:0]        l_wdata,
  output logic [DW-1:0]        l_rdata,
  output logic                 l_err,
  input  logic                 r_en,
  input  logic                 r_we,
  input  logic [DW/8-1:0]      r_be,
  input  logic [BANK_AW+1:0]   r_addr,
  input  logic [DW-1:0]        r_wdata,
  output logic [DW-1:0]        r_rdata,
  output logic                 r_err
);
  localparam int NBANK = 4;
  localparam int AW    = BANK_AW + 2;
  localparam int BW    = DW / 8;
  localparam int DEPTH = 1 << BANK_AW;

  logic [NBANK-1:0] own_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) own_q <= '0;
    else        own_q <= bank_sel;

  wire [1:0]         l_bank = l_addr[AW-1:BANK_AW];
  wire [1:0]         r_bank = r_addr[AW-1:BANK_AW];
  wire [BANK_AW-1:0] l_word = l_addr[BANK_AW-1:0];
  wire [BANK_AW-1:0] r_word = r_addr[BANK_AW-1:0];
  wire               l_ok   = own_q[l_bank];
  wire               r_ok   = ~own_q[r_bank];

  logic [DW-1:0] l_rd [NBANK];
  logic [DW-1:0] r_rd [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    wire               pick_l = own_q[b];
    wire               hit    = pick_l ? (l_en && l_we && l_bank == 2'(b))
                                       : (r_en && r_we && r_bank == 2'(b));
    wire [BW-1:0]      be     = pick_l ? l_be    : r_be;
    wire [BANK_AW-1:0] idx    = pick_l ? l_word  : r_word;
    wire [DW-1:0]      wd     = pick_l ? l_wdata : r_wdata;

    always_ff @(posedge clk)
      for (int i = 0; i < BW; i++)
        if (hit && be[i]) mem[idx][i*8 +: 8] <= wd[i*8 +: 8];

    assign l_rd[b] = mem[l_word];
    assign r_rd[b] = mem[r_word];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      l_rdata <= '0;
      l_err   <= 1'b0;
    end else begin
      l_err <= l_en && !l_ok;
      if (l_en && !l_ok)      l_rdata <= '0;
      else if (l_en && !l_we) l_rdata <= l_rd[l_bank];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      r_rdata <= '0;
      r_err   <= 1'b0;
    end else begin
      r_err <= r_en && !r_ok;
      if (r_en && !r_ok)      r_rdata <= '0;
      else if (r_en && !r_we) r_rdata <= r_rd[r_bank];
    end
endmodule

// File: rtl/bank_dpram_chk.sv
module bank_dpram_chk #(
  parameter int BANK_AW = 8,
  parameter int DW      = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               l_en,
  input logic [BANK_AW+1:0] l_addr,
  input logic [DW-1:0]      l_rdata,
  input logic               l_err,
  input logic               r_en,
  input logic [BANK_AW+1:0] r_addr,
  input logic [DW-1:0]      r_rdata,
  input logic               r_err
);
  // R5
  l_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_err |-> l_rdata == '0);
  // R5
  r_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_err |-> r_rdata == '0);
  // R10
  l_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !l_en |=> ($stable(l_rdata) && !l_err));
  // R10
  r_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !r_en |=> ($stable(r_rdata) && !r_err));
  // R2
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && r_en && l_addr[BANK_AW+1:BANK_AW] == r_addr[BANK_AW+1:BANK_AW])
      |=> (l_err != r_err));
  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (l_rdata == '0 && r_rdata == '0 && !l_err && !r_err));
endmodule

bind bank_dpram bank_dpram_chk #(.BANK_AW(BANK_AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_en(l_en), .l_addr(l_addr), .l_rdata(l_rdata), .l_err(l_err),
  .r_en(r_en), .r_addr(r_addr), .r_rdata(r_rdata), .r_err(r_err)
);

// File: tb/bank_dpram_tb.sv
`timescale 1ns/1ps
module bank_dpram_tb;
  localparam int BAW = 4;
  localparam int DW  = 16;

  logic clk = 0, rst_n = 0;
  logic [3:0] bank_sel = '0;
  logic l_en = 0, l_we = 0, r_en = 0, r_we = 0;
  logic [1:0] l_be = '0, r_be = '0;
  logic [BAW+1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_err, r_err;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  bank_dpram #(.BANK_AW(BAW), .DW(DW)) u_dut (.*);

  // {we, be[1:0], addr[5:0], wdata, exp_rdata, exp_err}, left port, banks 0,1 left
  localparam int NV = 13;
  localparam logic [41:0] VEC [NV] = '{
    {1'b1, 2'b11, 6'h03, 16'hA1B2, 16'h0000, 1'b0},
    {1'b0, 2'b00, 6'h03, 16'h0000, 16'hA1B2, 1'b0},
    {1'b1, 2'b11, 6'h15, 16'h1234, 16'hA1B2, 1'b0},
    {1'b1, 2'b01, 6'h15, 16'hFFCD, 16'hA1B2, 1'b0},
    {1'b0, 2'b00, 6'h15, 16'h0000, 16'h12CD, 1'b0},
    {1'b1, 2'b10, 6'h15, 16'h56FF, 16'h12CD, 1'b0},
    {1'b0, 2'b00, 6'h15, 16'h0000, 16'h56CD, 1'b0},
    {1'b1, 2'b11, 6'h25, 16'hDEAD, 16'h0000, 1'b1},
    {1'b0, 2'b00, 6'h25, 16'h0000, 16'h0000, 1'b1},
    {1'b0, 2'b00, 6'h03, 16'h0000, 16'hA1B2, 1'b0},
    {1'b1, 2'b11, 6'h05, 16'h0B0B, 16'hA1B2, 1'b0},
    {1'b0, 2'b00, 6'h15, 16'h0000, 16'h56CD, 1'b0},
    {1'b0, 2'b00, 6'h05, 16'h0000, 16'h0B0B, 1'b0}
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lop(input logic en, input logic we, input logic [1:0] be,
                     input logic [BAW+1:0] a, input logic [DW-1:0] d);
    l_en = en; l_we = we; l_be = be; l_addr = a; l_wdata = d;
  endtask

  task automatic rop(input logic en, input logic we, input logic [1:0] be,
                     input logic [BAW+1:0] a, input logic [DW-1:0] d);
    r_en = en; r_we = we; r_be = be; r_addr = a; r_wdata = d;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic nxt();
    @(negedge clk);
    lop(0, 0, 0, 0, 0);
    rop(0, 0, 0, 0, 0);
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bank_sel = 4'b0011;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 l_rdata", l_rdata, 0);
    chk("R9 r_rdata", r_rdata, 0);
    chk("R9 errs", {14'd0, l_err, r_err}, 0);
    @(negedge clk) rst_n = 1;
    cyc();
    nxt();

    for (int i = 0; i < NV; i++) begin
      lop(1, VEC[i][41], VEC[i][40:39], VEC[i][38:33], VEC[i][32:17]);
      cyc();
      chk($sformatf("R1/R3/R4/R5 vec%0d rdata", i), l_rdata, VEC[i][16:1]);
      chk($sformatf("R5 vec%0d err", i), {15'd0, l_err}, {15'd0, VEC[i][0]});
      nxt();
    end

    // R6: both ports write, then both read, in the same cycles
    lop(1, 1, 2'b11, 6'h07, 16'h1111);
    rop(1, 1, 2'b11, 6'h25, 16'h7777);
    cyc();
    chk("R6 write errs", {14'd0, l_err, r_err}, 0);
    nxt();
    lop(1, 0, 0, 6'h07, 0);
    rop(1, 0, 0, 6'h25, 0);
    cyc();
    chk("R6 left read", l_rdata, 16'h1111);
    chk("R6 right read", r_rdata, 16'h7777);
    nxt();

    // R5: refused writes leave owner's data intact
    lop(1, 1, 2'b11, 6'h25, 16'hDEAD);
    rop(1, 1, 2'b11, 6'h07, 16'hEEEE);
    cyc();
    chk("R5 left refused err", {15'd0, l_err}, 1);
    chk("R5 right refused rdata", r_rdata, 0);
    chk("R5 right refused err", {15'd0, r_err}, 1);
    nxt();
    lop(1, 0, 0, 6'h07, 0);
    rop(1, 0, 0, 6'h25, 0);
    cyc();
    chk("R5 right word intact", r_rdata, 16'h7777);
    chk("R5 left word intact", l_rdata, 16'h1111);
    chk("R5 err one cycle", {14'd0, l_err, r_err}, 0);
    nxt();

    // R10: idle keeps data; R3: result appears only after the edge
    cyc();
    chk("R10 idle hold", l_rdata, 16'h1111);
    chk("R10 idle no err", {15'd0, l_err}, 0);
    nxt();
    lop(1, 0, 0, 6'h03, 0);
    #1;
    chk("R3 before edge", l_rdata, 16'h1111);
    cyc();
    chk("R3 after edge", l_rdata, 16'hA1B2);
    nxt();

    // R8: ownership change in the same cycle as an access
    bank_sel = 4'b0111;
    lop(1, 0, 0, 6'h25, 0);
    cyc();
    chk("R8 old owner applies", {15'd0, l_err}, 1);
    nxt();
    lop(1, 0, 0, 6'h25, 0);
    cyc();
    chk("R8 new owner applies", l_rdata, 16'h7777);
    chk("R8 new owner no err", {15'd0, l_err}, 0);
    nxt();

    // R7: all banks left, then all banks right
    bank_sel = 4'b1111;
    cyc();
    nxt();
    lop(1, 0, 0, 6'h25, 0);
    rop(1, 0, 0, 6'h03, 0);
    cyc();
    chk("R7 all-left read", l_rdata, 16'h7777);
    chk("R7 all-left right err", {15'd0, r_err}, 1);
    nxt();
    bank_sel = 4'b0000;
    cyc();
    nxt();
    rop(1, 0, 0, 6'h03, 0);
    lop(1, 0, 0, 6'h07, 0);
    cyc();
    chk("R7 all-right read", r_rdata, 16'hA1B2);
    chk("R7 all-right left err", {15'd0, l_err}, 1);
    nxt();
    rop(1, 0, 0, 6'h15, 0);
    cyc();
    chk("R2 R1 right owns bank1", r_rdata, 16'h56CD);
    nxt();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule